// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

This block is a first-in first-out buffer of 256 words of 9 bits whose write and read ports run on independent clocks. Pointers cross between the two domains as gray code through two-flop synchronizers. Four active-low status outputs are provided. Empty and almost-empty live in the read domain. Full and almost-full live in the write domain. Because each side sees the other's pointer late, the flags are conservative but never report room or data that does not exist.

The almost thresholds come from two offset registers that are set at run time. A dual-purpose control pin is sampled while reset is high. If it is sampled high, the pin becomes a second, active-high write enable. If it is sampled low, driving the pin low turns the data ports into access ports for the offset registers. Writes then load those registers in a fixed rotating order. Reads return them in the same order.

The read data output is held in a register. An active-low output enable decides whether the word is driven. The undriven state is modelled as a low drive flag with the data forced to zero.

Top module: `dualclk_fifo_pf`

## Requirements
- R1: While `rst` is high and after it falls, `empty_n`=0, `aempty_n`=0, `full_n`=1 and `afull_n`=1. Both offsets are 7, and both offset step pointers are at the first register.
- R2: A word is stored on a `wr_clk` rising edge exactly when `wr_en1_n`=0, `mode_pin`=1 and `full_n`=1. This holds in both pin modes.
- R3: A word is removed on an `rd_clk` rising edge exactly when `rd_en1_n`=0, `rd_en2_n`=0 and `empty_n`=1, and the design is not in load mode with `mode_pin`=0. That word appears on `rd_data` after that edge, in write order.
- R4: `full_n` goes low once 256 words are held. A write attempted while `full_n`=0 is dropped.
- R5: A read attempted while `empty_n`=0, or with either read enable high, leaves `rd_data` and the contents unchanged.
- R6: `mode_pin` is latched on every `wr_clk` and `rd_clk` edge while `rst`=1. Latched high gives enable mode: a low `mode_pin` only blocks writes, and the offsets cannot be reached. Latched low gives load mode.
- R7: In load mode, a `wr_clk` edge with `mode_pin`=0 and `wr_en1_n`=0 stores `wr_data` into the offset register at the write step pointer, then advances the pointer. The order is: almost-empty bits 7:0 from `wr_data[7:0]`, almost-empty bit 8 from `wr_data[0]`, almost-full bits 7:0, almost-full bit 8. After the fourth register the order wraps to the first. The FIFO contents are not touched.
- R8: In load mode, an `rd_clk` edge with `mode_pin`=0 and both read enables low puts the offset register at the read step pointer on `rd_data`, then advances that pointer. The order is the same as in R7. A low byte is returned zero-extended. A high bit is returned in bit 0. No word is removed.
- R9: `aempty_n` is low exactly when the read-side occupancy is at most the almost-empty offset.
- R10: `afull_n` is low exactly when the write-side occupancy is at least 256 minus the almost-full offset. An offset above 256 gives a threshold of 0.
- R11: `empty_n` and `aempty_n` change only in the read domain. `full_n` and `afull_n` change only in the write domain. Just after a write into an empty FIFO, `empty_n` is still low. Just after a read from a full FIFO, `full_n` is still low.
- R12: With `oe_n`=1, `rd_drive`=0 and `rd_data`=0. With `oe_n`=0, `rd_drive`=1 and `rd_data` shows the held output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, seen by both domains |
| wr_data | input | 9 | Word to store, or offset value in load mode |
| wr_en1_n | input | 1 | Active-low write enable |
| mode_pin | input | 1 | Second write enable (active high) or offset access control (active low), chosen at reset |
| rd_en1_n | input | 1 | Active-low read enable, first of two |
| rd_en2_n | input | 1 | Active-low read enable, second of two |
| oe_n | input | 1 | Active-low output enable for the data port |
| rd_data | output | 9 | Held output word, zero when not driven |
| rd_drive | output | 1 | High when the data port is driven |
| empty_n | output | 1 | Low when empty (read domain) |
| aempty_n | output | 1 | Low when almost empty (read domain) |
| full_n | output | 1 | Low when full (write domain) |
| afull_n | output | 1 | Low when almost full (write domain) |

## Verification
The bench builds the block with its default parameters: 9-bit words, an 8-bit address giving 256 entries, two synchronizer stages and a default offset of 7. At this depth, full and the boundary words around each threshold can be reached in a few hundred writes. That includes the 248/249 edge under the default almost-full offset and the 155/156 edge after an offset of 100 is loaded. The bench also sets the offset high bit so the threshold reaches the full depth, and it runs both reset-latched pin modes.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  // Offset register order; the step pointers walk this sequence and wrap.
  typedef enum logic [1:0] {
    OFS_AE_LO = 2'd0,
    OFS_AE_HI = 2'd1,
    OFS_AF_LO = 2'd2,
    OFS_AF_HI = 2'd3
  } ofs_sel_t;
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 8
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
`timescale 1ns/1ps
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int ADDR_W  = 8,
  parameter int DEF_OFS = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en1_n,
  input  logic              mode_pin,
  input  logic [ADDR_W:0]   rgray_sync,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ADDR_W:0]   wgray,
  output logic              full_n,
  output logic              afull_n,
  output logic [ADDR_W:0]   ae_ofs,
  output logic [ADDR_W:0]   af_ofs
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);
  localparam logic [PW-1:0] DEF_P   = PW'(DEF_OFS);

  logic          mode_load;
  logic [PW-1:0] wbin, wbin_nx, rbin_s, cnt_nx, af_thr;
  logic          full_r, afull_r;
  logic [1:0]    step;
  logic          push, ld;

  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_sync >> i);
  end

  assign push    = !wr_en1_n && mode_pin && !full_r;
  assign ld      = mode_load && !mode_pin && !wr_en1_n;
  assign wbin_nx = wbin + PW'(push);
  assign cnt_nx  = wbin_nx - rbin_s;
  assign af_thr  = (af_ofs > DEPTH_P) ? '0 : (DEPTH_P - af_ofs);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_load <= !mode_pin;
      wbin      <= '0;
      wgray     <= '0;
      full_r    <= 1'b0;
      afull_r   <= 1'b0;
      step      <= OFS_AE_LO;
      ae_ofs    <= DEF_P;
      af_ofs    <= DEF_P;
    end else begin
      wbin    <= wbin_nx;
      wgray   <= wbin_nx ^ (wbin_nx >> 1);
      full_r  <= (cnt_nx == DEPTH_P);
      afull_r <= (cnt_nx >= af_thr);
      if (ld) begin
        case (ofs_sel_t'(step))
          OFS_AE_LO: ae_ofs[ADDR_W-1:0] <= wr_data[ADDR_W-1:0];
          OFS_AE_HI: ae_ofs[ADDR_W]     <= wr_data[0];
          OFS_AF_LO: af_ofs[ADDR_W-1:0] <= wr_data[ADDR_W-1:0];
          default:   af_ofs[ADDR_W]     <= wr_data[0];
        endcase
        step <= step + 2'd1;
      end
    end
  end

  assign mem_we    = push;
  assign mem_waddr = wbin[ADDR_W-1:0];
  assign mem_wdata = wr_data;
  assign full_n    = !full_r;
  assign afull_n   = !afull_r;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (PW'(wbin - rbin_s) <= DEPTH_P)) else $error("write side count above depth"); // R4
  AST_FULL_DROPS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (full_r && !wr_en1_n && mode_pin) |=> $stable(wbin)) else $error("write accepted while full"); // R4
  AST_FULL_IN_AFULL: assert property (@(posedge clk) disable iff (rst)
    full_r |-> afull_r) else $error("full without almost full"); // R10
  AST_LOAD_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
    ld |=> $stable(wbin)) else $error("offset load moved write pointer"); // R7
  AST_LOAD_STEP: assert property (@(posedge clk) disable iff (rst)
    ld |=> (step == $past(step) + 2'd1)) else $error("offset step did not advance"); // R7
endmodule

// File: rtl/dcf_rd_ctl.sv
`timescale 1ns/1ps
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en1_n,
  input  logic              rd_en2_n,
  input  logic              mode_pin,
  input  logic              oe_n,
  input  logic [ADDR_W:0]   wgray_sync,
  input  logic [ADDR_W:0]   ae_ofs,
  input  logic [ADDR_W:0]   af_ofs,
  input  logic [DATA_W-1:0] mem_q,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic [ADDR_W:0]   rgray,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive,
  output logic              empty_n,
  output logic              aempty_n
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);

  logic              mode_load;
  logic [PW-1:0]     rbin, rbin_nx, wbin_s, cnt_nx;
  logic              empty_r, aempty_r;
  logic [1:0]        rstep;
  logic              pop, rb, sel_ofs;
  logic [DATA_W-1:0] ofs_q, ofs_word;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_sync >> i);
  end

  assign rb      = mode_load && !mode_pin && !rd_en1_n && !rd_en2_n;
  assign pop     = !rd_en1_n && !rd_en2_n && !empty_r && !(mode_load && !mode_pin);
  assign rbin_nx = rbin + PW'(pop);
  assign cnt_nx  = wbin_s - rbin_nx;

  always_comb begin
    case (ofs_sel_t'(rstep))
      OFS_AE_LO: ofs_word = DATA_W'(ae_ofs[ADDR_W-1:0]);
      OFS_AE_HI: ofs_word = DATA_W'(ae_ofs[ADDR_W]);
      OFS_AF_LO: ofs_word = DATA_W'(af_ofs[ADDR_W-1:0]);
      default:   ofs_word = DATA_W'(af_ofs[ADDR_W]);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_load <= !mode_pin;
      rbin      <= '0;
      rgray     <= '0;
      empty_r   <= 1'b1;
      aempty_r  <= 1'b1;
      rstep     <= OFS_AE_LO;
      sel_ofs   <= 1'b0;
      ofs_q     <= '0;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= rbin_nx ^ (rbin_nx >> 1);
      empty_r  <= (cnt_nx == '0);
      aempty_r <= (cnt_nx <= ae_ofs);
      if (rb) begin
        ofs_q   <= ofs_word;
        sel_ofs <= 1'b1;
        rstep   <= rstep + 2'd1;
      end else if (pop) begin
        sel_ofs <= 1'b0;
      end
    end
  end

  assign mem_re    = pop;
  assign mem_raddr = rbin[ADDR_W-1:0];
  assign rd_drive  = !oe_n;
  assign rd_data   = oe_n ? '0 : (sel_ofs ? ofs_q : mem_q);
  assign empty_n   = !empty_r;
  assign aempty_n  = !aempty_r;

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (PW'(wbin_s - rbin) <= DEPTH_P)) else $error("read pointer passed write pointer"); // R5
  AST_EMPTY_DROPS_READ: assert property (@(posedge clk) disable iff (rst)
    (empty_r && !rd_en1_n && !rd_en2_n) |=> $stable(rbin)) else $error("read accepted while empty"); // R5
  AST_EMPTY_IN_AEMPTY: assert property (@(posedge clk) disable iff (rst)
    empty_r |-> aempty_r) else $error("empty without almost empty"); // R9
  AST_READBACK_NO_POP: assert property (@(posedge clk) disable iff (rst)
    rb |=> $stable(rbin)) else $error("offset readback moved read pointer"); // R8
endmodule

// File: rtl/dualclk_fifo_pf.sv
`timescale 1ns/1ps
module dualclk_fifo_pf #(
  parameter int DATA_W      = 9,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DEF_OFS     = 7
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en1_n,
  input  logic              mode_pin,
  input  logic              rd_en1_n,
  input  logic              rd_en2_n,
  input  logic              oe_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive,
  output logic              empty_n,
  output logic              aempty_n,
  output logic              full_n,
  output logic              afull_n
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s, ae_ofs, af_ofs;
  logic              mem_we, mem_re;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_wdata, mem_q;

  dcf_wr_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEF_OFS(DEF_OFS)) u_wr (
    .clk(wr_clk), .rst(rst), .wr_data(wr_data), .wr_en1_n(wr_en1_n),
    .mode_pin(mode_pin), .rgray_sync(rgray_s), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .wgray(wgray),
    .full_n(full_n), .afull_n(afull_n), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst(rst), .din(rgray), .dout(rgray_s)
  );

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst(rst), .din(wgray), .dout(wgray_s)
  );

  dcf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .rclk(rd_clk), .re(mem_re), .raddr(mem_raddr), .rdata(mem_q)
  );

  dcf_rd_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(rd_clk), .rst(rst), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
    .mode_pin(mode_pin), .oe_n(oe_n), .wgray_sync(wgray_s),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .mem_q(mem_q), .mem_re(mem_re),
    .mem_raddr(mem_raddr), .rgray(rgray), .rd_data(rd_data),
    .rd_drive(rd_drive), .empty_n(empty_n), .aempty_n(aempty_n)
  );
endmodule

// File: tb/dualclk_fifo_pf_test.sv
`timescale 1ns/1ps
module dualclk_fifo_pf_test;
  logic       wr_clk = 0, rd_clk = 0, rst = 1;
  logic [8:0] wr_data = 0;
  logic       wr_en1_n = 1, mode_pin = 1, rd_en1_n = 1, rd_en2_n = 1, oe_n = 0;
  logic [8:0] rd_data;
  logic       rd_drive, empty_n, aempty_n, full_n, afull_n;

  int checks = 0, errors = 0;
  int q[$];
  int ae_m = 7, af_m = 7;

  dualclk_fifo_pf uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .wr_data(wr_data),
    .wr_en1_n(wr_en1_n), .mode_pin(mode_pin), .rd_en1_n(rd_en1_n),
    .rd_en2_n(rd_en2_n), .oe_n(oe_n), .rd_data(rd_data), .rd_drive(rd_drive),
    .empty_n(empty_n), .aempty_n(aempty_n), .full_n(full_n), .afull_n(afull_n)
  );

  always #5 wr_clk = ~wr_clk;
  initial begin #3; forever #5 rd_clk = ~rd_clk; end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_aempty_n(input int n);
    return (n <= ae_m) ? 0 : 1;
  endfunction

  function automatic int exp_afull_n(input int n);
    int thr;
    thr = (af_m > 256) ? 0 : 256 - af_m;
    return (n >= thr) ? 0 : 1;
  endfunction

  task automatic do_reset(input bit load_mode);
    @(negedge wr_clk);
    rst = 1; wr_en1_n = 1; rd_en1_n = 1; rd_en2_n = 1;
    mode_pin = load_mode ? 1'b0 : 1'b1;
    repeat (5) @(posedge wr_clk);
    repeat (2) @(posedge rd_clk);
    @(negedge wr_clk);
    rst = 0; mode_pin = 1;
    q.delete(); ae_m = 7; af_m = 7;
    #1;
  endtask

  task automatic settle_check(input string tag);
    int n;
    repeat (8) @(posedge wr_clk);
    repeat (8) @(posedge rd_clk);
    #2;
    n = q.size();
    chk("R5",  {tag, " empty_n"},  int'(empty_n),  (n != 0) ? 1 : 0);
    chk("R4",  {tag, " full_n"},   int'(full_n),   (n != 256) ? 1 : 0);
    chk("R9",  {tag, " aempty_n"}, int'(aempty_n), exp_aempty_n(n));
    chk("R10", {tag, " afull_n"},  int'(afull_n),  exp_afull_n(n));
  endtask

  // R2: store only when wr_en1_n low, mode_pin high and full_n high
  task automatic wr_word(input int d, input bit en2);
    bit go;
    @(negedge wr_clk);
    wr_data = d[8:0]; wr_en1_n = 0; mode_pin = en2;
    go = full_n && en2;
    @(posedge wr_clk); #1;
    wr_en1_n = 1; mode_pin = 1;
    if (go) q.push_back(d & 511);
  endtask

  task automatic ofs_wr(input int d);
    @(negedge wr_clk);
    wr_data = d[8:0]; wr_en1_n = 0; mode_pin = 0;
    @(posedge wr_clk); #1;
    wr_en1_n = 1; mode_pin = 1;
  endtask

  // R3 / R5: removal only with both enables low and empty_n high
  task automatic rd_word(input bit blk2);
    bit go; int prev, e;
    @(negedge rd_clk);
    rd_en1_n = 0; rd_en2_n = blk2;
    go = empty_n && !blk2;
    prev = int'(rd_data);
    @(posedge rd_clk); #1;
    rd_en1_n = 1; rd_en2_n = 1;
    if (go) begin
      e = q.pop_front();
      chk("R3", "read data order", int'(rd_data), e);
    end else begin
      chk("R5", "ignored read keeps output", int'(rd_data), prev);
    end
  endtask

  task automatic rb_word(input int e, input string tag);
    @(negedge rd_clk);
    mode_pin = 0; rd_en1_n = 0; rd_en2_n = 0;
    @(posedge rd_clk); #1;
    rd_en1_n = 1; rd_en2_n = 1; mode_pin = 1;
    chk("R8", tag, int'(rd_data), e);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));

    // ---------------- enable mode ----------------
    do_reset(0);
    chk("R1", "reset empty_n", int'(empty_n), 0);
    chk("R1", "reset aempty_n", int'(aempty_n), 0);
    chk("R1", "reset full_n", int'(full_n), 1);
    chk("R1", "reset afull_n", int'(afull_n), 1);

    rd_word(0);  // read on empty: R5
    settle_check("empty after ignored read");

    // R9 boundary with default offset 7
    for (int i = 0; i < 7; i++) wr_word(100 + i, 1);
    settle_check("R9 seven words");
    wr_word(107, 1);
    settle_check("R9 eight words");

    // R12 output enable
    rd_word(0);
    oe_n = 1; #1;
    chk("R12", "drive off", int'(rd_drive), 0);
    chk("R12", "data zero when off", int'(rd_data), 0);
    oe_n = 0; #1;
    chk("R12", "drive on", int'(rd_drive), 1);
    chk("R12", "data back when on", int'(rd_data), 100);
    while (q.size() > 0) rd_word(0);

    // R6: enable mode, low mode_pin blocks the write
    wr_word(321, 0);
    settle_check("R6 blocked write");
    chk("R6", "enable mode blocked write count", q.size(), 0);

    // R11: empty flag still low right after the first write
    wr_word(55, 1);
    chk("R11", "empty_n just after write", int'(empty_n), 0);
    settle_check("R11 one word");
    rd_word(1);  // second enable high: ignored (R5)
    rd_word(0);

    // fill, R10 boundary at 249 with default offset
    for (int i = 0; i < 248; i++) wr_word(i * 3, 1);
    settle_check("R10 248 words");
    wr_word(7, 1);
    settle_check("R10 249 words");
    while (q.size() < 256) wr_word($urandom % 512, 1);
    settle_check("R4 full");
    wr_word(9, 1);  // dropped while full
    chk("R4", "count after write while full", q.size(), 256);
    rd_word(0);
    chk("R11", "full_n just after read", int'(full_n), 0);
    while (q.size() > 0) rd_word(0);
    settle_check("drained");

    // constrained random traffic
    for (int i = 0; i < 500; i++) begin
      int r = $urandom % 4;
      if (r != 0) wr_word($urandom % 512, 1); else rd_word(($urandom % 4) == 0);
      if (i % 100 == 99) settle_check("random fill");
    end
    for (int i = 0; i < 600; i++) begin
      int r = $urandom % 4;
      if (r == 0) wr_word($urandom % 512, ($urandom % 5) != 0); else rd_word(($urandom % 5) == 0);
      if (i % 100 == 99) settle_check("random drain");
    end

    // ---------------- load mode ----------------
    do_reset(1);
    chk("R1", "load reset empty_n", int'(empty_n), 0);
    rb_word(7, "default ae low");
    rb_word(0, "default ae high");
    rb_word(7, "default af low");
    rb_word(0, "default af high");

    // R7 order: ae lo, ae hi, af lo, af hi
    ofs_wr(20); ofs_wr(0); ofs_wr(100); ofs_wr(0);
    ae_m = 20; af_m = 100;
    rb_word(20, "loaded ae low");
    rb_word(0, "loaded ae high");
    rb_word(100, "loaded af low");
    rb_word(0, "loaded af high");
    settle_check("R7 no FIFO change from load");
    chk("R7", "offset load left FIFO empty", int'(empty_n), 0);

    for (int i = 0; i < 20; i++) wr_word(200 + i, 1);  // R2 in load mode
    settle_check("R9 loaded 20");
    wr_word(220, 1);
    settle_check("R9 loaded 21");
    while (q.size() < 155) wr_word($urandom % 512, 1);
    settle_check("R10 loaded 155");
    wr_word(1, 1);
    settle_check("R10 loaded 156");

    // wrap: step back at ae low; set ae = 256 via high bit
    ofs_wr(0); ofs_wr(1);
    ae_m = 256;
    settle_check("R7 wrapped ae 256");
    rb_word(0, "wrapped ae low");
    rb_word(1, "wrapped ae high");

    rd_word(0);  // pop after readback returns FIFO data
    settle_check("load mode after pop");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule